// File: doc/BRIEF.md
# Sequential-Address Memory Traffic Tester

The block drives a memory controller's request port to check that every word in a chosen address window can be written and read back intact. A pass has two halves. The write half walks the window in a fixed order and stores one pseudo-random word per address. The words come from a 32-bit shift-register generator that advances on each accepted write. The read half walks the same window in the same order. A second copy of the generator, restarted from the same seed, rebuilds each expected word as its read data arrives. No table of written data is kept.

The window is set by three independent counts: rows, banks and columns. Setting each count to the device's size covers the whole memory. Setting them smaller covers a corner of it. Requests use a valid/ready handshake. Read data returns on a valid-only strobe, in request order, with any latency and any number of reads outstanding. When a pass ends, a one-cycle completion pulse is raised together with a pass indication, and the next pass starts at once. A sticky fail flag and the address of the first failing word stay visible until reset. When the enable is low at the start of a pass, that pass is skipped entirely.

Top module: `seq_mem_tester`

## Requirements
- R1: The write half issues one write per address. Column changes fastest, then bank, then row. The flat address is {row, bank, col}, with col in the low COL_W bits. `req_write` is 1. Each write's data is the next value of the generator sequence, counted from the seed.
- R2: The generator is a right-shifting Galois register. On each step the state shifts right by one; if the bit shifted out was 1, the result is XORed with 32'h80200003 (polynomial x^32+x^22+x^2+x+1). The seed is 32'h5EED0001. Data bit i equals state bit (i mod 32).
- R3: A request transfers on a cycle where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_write` and `req_wdata` hold their values. No request is dropped or repeated.
- R4: Read requests (`req_write` = 0) start only after the last write of the pass has been accepted, with at least one idle cycle between them. They cover the same addresses in the same order as the writes.
- R5: Each `rd_valid` beat is compared with the regenerated word for the next address in request order. Fixed latencies of 1 to 7 cycles are accepted.
- R6: `done` is high for exactly one cycle, on the cycle after the last read beat is taken. If the enable is high, the next cycle begins a new write half at the first address, with the generator back at its seed.
- R7: `pass_ok` is high only together with `done`. It is high exactly when no read beat of the finished pass mismatched.
- R8: `fail_sticky` rises after the first mismatching beat and stays high until reset. `fail_addr` holds the address of that first failing word and is not changed by later mismatches.
- R9: `seq_en` is sampled only when a pass is about to start. If it is low then, no request is issued, and `done` and `pass_ok` are high on every cycle until it is sampled high. Changing it in the middle of a pass has no effect on that pass.
- R10: In reset and on the first cycle after it, `req_valid`, `done`, `pass_ok` and `fail_sticky` are 0 and `fail_addr` is 0.
- R11: ROW_CNT, BANK_CNT and COL_CNT each bound their own field independently. A count smaller than 2^width stops that field at count-1 before it wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_en | input | 1 | Enables the next pass; low skips it |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Controller accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ROW_W+BANK_W+COL_W | Flat address {row, bank, col} |
| req_wdata | output | DATA_W | Write data |
| rd_valid | input | 1 | Read data beat present |
| rd_data | input | DATA_W | Read data |
| done | output | 1 | Pass completed (one cycle per pass) |
| pass_ok | output | 1 | Completed pass had no mismatch |
| fail_sticky | output | 1 | A mismatch has been seen since reset |
| fail_addr | output | ROW_W+BANK_W+COL_W | Address of the first failing word |

## Verification
The assertions assume that the controller returns read beats only for reads it has accepted, in request order, and never asserts `rd_valid` outside the read half. They also assume that `req_ready` may fall at any time, because the tester must hold its payload while stalled. The bench models a memory that replies only to accepted reads, through an in-order queue with a fixed latency per pass, so it never goes outside those assumptions. It varies the ready patterns, the latencies and single-word corruptions from pass to pass. It changes `seq_en` only just after a clock edge.

// File: rtl/smt_pkg.sv
package smt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RESEED,
    ST_READ,
    ST_DONE
  } smt_state_e;

  localparam logic [31:0] GEN_SEED = 32'h5EED_0001;
  localparam logic [31:0] GEN_TAPS = 32'h8020_0003;

  function automatic logic [31:0] gen_step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? GEN_TAPS : 32'h0);
  endfunction
endpackage

// File: rtl/smt_lfsr.sv
module smt_lfsr #(
  parameter int DATA_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              step,
  output logic [DATA_W-1:0] word
);
  import smt_pkg::*;

  logic [31:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n || reseed) state_q <= GEN_SEED;
    else if (step)        state_q <= gen_step(state_q);
  end

  // widen or narrow the 32-bit state onto the data bus
  for (genvar i = 0; i < DATA_W; i++) begin : g_map
    assign word[i] = state_q[i % 32];
  end
endmodule

// File: rtl/smt_addr_gen.sv
module smt_addr_gen #(
  parameter int ROW_W    = 2,
  parameter int BANK_W   = 1,
  parameter int COL_W    = 3,
  parameter int ROW_CNT  = 3,
  parameter int BANK_CNT = 2,
  parameter int COL_CNT  = 4,
  localparam int ADDR_W  = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ROW_W-1:0]  ROW_END  = ROW_W'(ROW_CNT - 1);
  localparam logic [BANK_W-1:0] BANK_END = BANK_W'(BANK_CNT - 1);
  localparam logic [COL_W-1:0]  COL_END  = COL_W'(COL_CNT - 1);

  logic [ROW_W-1:0]  row_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic              col_wrap, bank_wrap, row_wrap;

  assign col_wrap  = (col_q == COL_END);
  assign bank_wrap = (bank_q == BANK_END);
  assign row_wrap  = (row_q == ROW_END);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      row_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else if (step) begin
      col_q <= col_wrap ? '0 : col_q + 1'b1;
      if (col_wrap) begin
        bank_q <= bank_wrap ? '0 : bank_q + 1'b1;
        if (bank_wrap) row_q <= row_wrap ? '0 : row_q + 1'b1;
      end
    end
  end

  assign addr = {row_q, bank_q, col_q};
  assign last = col_wrap && bank_wrap && row_wrap;
endmodule

// File: rtl/smt_compare.sv
module smt_compare #(
  parameter int DATA_W = 40,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass_clear,
  input  logic              chk_valid,
  input  logic [DATA_W-1:0] got,
  input  logic [DATA_W-1:0] want,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              pass_err,
  output logic              fail_sticky,
  output logic [ADDR_W-1:0] fail_addr
);
  logic miss;
  assign miss = chk_valid && (got != want);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_err    <= 1'b0;
      fail_sticky <= 1'b0;
      fail_addr   <= '0;
    end else begin
      if (pass_clear) pass_err <= 1'b0;
      else if (miss)  pass_err <= 1'b1;
      if (miss && !fail_sticky) begin
        fail_sticky <= 1'b1;
        fail_addr   <= chk_addr;
      end
    end
  end
endmodule

// File: rtl/seq_mem_tester.sv
module seq_mem_tester #(
  parameter int ROW_W    = 2,
  parameter int BANK_W   = 1,
  parameter int COL_W    = 3,
  parameter int ROW_CNT  = 3,
  parameter int BANK_CNT = 2,
  parameter int COL_CNT  = 4,
  parameter int DATA_W   = 40
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            seq_en,
  output logic                            req_valid,
  input  logic                            req_ready,
  output logic                            req_write,
  output logic [ROW_W+BANK_W+COL_W-1:0]   req_addr,
  output logic [DATA_W-1:0]               req_wdata,
  input  logic                            rd_valid,
  input  logic [DATA_W-1:0]               rd_data,
  output logic                            done,
  output logic                            pass_ok,
  output logic                            fail_sticky,
  output logic [ROW_W+BANK_W+COL_W-1:0]   fail_addr
);
  import smt_pkg::*;

  localparam int ADDR_W = ROW_W + BANK_W + COL_W;

  smt_state_e        state_q, state_d;
  logic              fire, wr_fire, rd_fire, beat;
  logic              reads_issued_q;
  logic              iss_last, ret_last, iss_clear;
  logic [ADDR_W-1:0] iss_addr, ret_addr;
  logic [DATA_W-1:0] wr_word, exp_word;
  logic              pass_err;

  assign fire    = req_valid && req_ready;
  assign wr_fire = fire && (state_q == ST_WRITE);
  assign rd_fire = fire && (state_q == ST_READ);
  assign beat    = rd_valid && (state_q == ST_READ);
  assign iss_clear = (state_q == ST_IDLE) || (state_q == ST_RESEED) || (state_q == ST_DONE);

  // request side: address walker and write-data generator
  smt_addr_gen #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W),
    .ROW_CNT(ROW_CNT), .BANK_CNT(BANK_CNT), .COL_CNT(COL_CNT)
  ) u_iss_addr (
    .clk(clk), .rst_n(rst_n), .clear(iss_clear), .step(fire),
    .addr(iss_addr), .last(iss_last)
  );

  smt_lfsr #(.DATA_W(DATA_W)) u_wr_gen (
    .clk(clk), .rst_n(rst_n), .reseed(iss_clear), .step(wr_fire),
    .word(wr_word)
  );

  // return side: address walker and expected-data generator, paced by beats
  smt_addr_gen #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W),
    .ROW_CNT(ROW_CNT), .BANK_CNT(BANK_CNT), .COL_CNT(COL_CNT)
  ) u_ret_addr (
    .clk(clk), .rst_n(rst_n), .clear(state_q == ST_RESEED), .step(beat),
    .addr(ret_addr), .last(ret_last)
  );

  smt_lfsr #(.DATA_W(DATA_W)) u_exp_gen (
    .clk(clk), .rst_n(rst_n), .reseed(state_q == ST_RESEED), .step(beat),
    .word(exp_word)
  );

  smt_compare #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .pass_clear((state_q == ST_IDLE) || (state_q == ST_DONE)),
    .chk_valid(beat), .got(rd_data), .want(exp_word), .chk_addr(ret_addr),
    .pass_err(pass_err), .fail_sticky(fail_sticky), .fail_addr(fail_addr)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   state_d = seq_en ? ST_WRITE : ST_DONE;
      ST_WRITE:  if (wr_fire && iss_last) state_d = ST_RESEED;
      ST_RESEED: state_d = ST_READ;
      ST_READ:   if (beat && ret_last) state_d = ST_DONE;
      ST_DONE:   state_d = seq_en ? ST_WRITE : ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      reads_issued_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RESEED)       reads_issued_q <= 1'b0;
      else if (rd_fire && iss_last)   reads_issued_q <= 1'b1;
    end
  end

  assign req_valid = (state_q == ST_WRITE) || ((state_q == ST_READ) && !reads_issued_q);
  assign req_write = (state_q == ST_WRITE);
  assign req_addr  = iss_addr;
  assign req_wdata = wr_word;
  assign done      = (state_q == ST_DONE);
  assign pass_ok   = done && !pass_err;
endmodule

// File: rtl/smt_props.sv
module smt_props #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              done,
  input logic              pass_ok,
  input logic              fail_sticky,
  input logic [ADDR_W-1:0] fail_addr
);
  p_hold_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata));

  p_gap_before_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !(req_valid && !req_write));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && seq_en |=> !done);

  p_ok_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_ok |-> done);

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_sticky |=> fail_sticky && $stable(fail_addr));

  p_quiet_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
endmodule

bind seq_mem_tester smt_props #(
  .ADDR_W(ROW_W + BANK_W + COL_W), .DATA_W(DATA_W)
) u_props (
  .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata), .done(done), .pass_ok(pass_ok),
  .fail_sticky(fail_sticky), .fail_addr(fail_addr)
);

// File: tb/tb_seq_mem_tester.sv
module tb_seq_mem_tester;
  localparam int ROW_W = 2, BANK_W = 1, COL_W = 3;
  localparam int ROW_CNT = 3, BANK_CNT = 2, COL_CNT = 4;
  localparam int DATA_W = 40;
  localparam int ADDR_W = ROW_W + BANK_W + COL_W;
  localparam int NWORDS = ROW_CNT * BANK_CNT * COL_CNT;

  logic clk = 0, rst_n = 0, seq_en = 1;
  logic req_valid, req_ready = 0, req_write;
  logic [ADDR_W-1:0] req_addr, fail_addr;
  logic [DATA_W-1:0] req_wdata, rd_data = '0;
  logic rd_valid = 0, done, pass_ok, fail_sticky;

  seq_mem_tester #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W),
    .ROW_CNT(ROW_CNT), .BANK_CNT(BANK_CNT), .COL_CNT(COL_CNT), .DATA_W(DATA_W)
  ) dut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] gstep(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h80200003) : (s >> 1);
  endfunction
  function automatic logic [DATA_W-1:0] widen(input logic [31:0] s);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) w[i] = s[i % 32];
    return w;
  endfunction
  function automatic logic [ADDR_W-1:0] addr_of(input int i);
    int c, b, r;
    c = i % COL_CNT;
    b = (i / COL_CNT) % BANK_CNT;
    r = i / (COL_CNT * BANK_CNT);
    return ADDR_W'((r << (BANK_W + COL_W)) | (b << COL_W) | c);
  endfunction
  function automatic int lat_of(input int p);
    return 1 + (p % 4) * 2;
  endfunction
  function automatic int bad_of(input int p);
    return (p == 2) ? 10 : (p == 4) ? 5 : -1;
  endfunction

  logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
  logic [DATA_W-1:0] q_dat [0:63];
  int q_due [0:63];
  int qh = 0, qt = 0, cyc = 0;
  int pass_no = 0, wcnt = 0, rqcnt = 0, retcnt = 0;
  logic [31:0] gen = 32'h5EED0001;
  bit cur_full = 1, bad_seen = 0, exp_fail = 0, prev_done_full = 0;
  logic [ADDR_W-1:0] exp_faddr = '0;
  bit hold_pend = 0;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_data;
  logic h_wr;
  bit finished = 0;

  always @(negedge clk) if (rst_n && !finished) begin
    cyc++;
    if (qh != qt && q_due[qh % 64] <= cyc) begin
      rd_valid = 1; rd_data = q_dat[qh % 64]; qh++; retcnt++;
    end else begin
      rd_valid = 0;
    end
    if (hold_pend)
      chk(req_valid && req_addr == h_addr && req_wdata == h_data && req_write == h_wr,
          "R3 payload held while stalled", 64'(req_addr), 64'(h_addr));
    if (prev_done_full)
      chk(!done, "R6 done lasts one cycle", 64'(done), 0);
    if (!cur_full)
      chk(!req_valid, "R9 no request in skipped pass", 64'(req_valid), 0);
    req_ready = (pass_no % 2 == 0) ? 1'b1 : (cyc % 3 != 0);
    hold_pend = req_valid && !req_ready;
    h_addr = req_addr; h_data = req_wdata; h_wr = req_write;
    if (req_valid && req_ready) begin
      if (req_write) begin
        chk(req_addr == addr_of(wcnt), "R1 R11 write address order", 64'(req_addr), 64'(addr_of(wcnt)));
        chk(req_wdata == widen(gen), "R1 R2 write data", 64'(req_wdata), 64'(widen(gen)));
        chk(rqcnt == 0, "R4 write after read in same pass", rqcnt, 0);
        mem[req_addr] = req_wdata;
        gen = gstep(gen);
        wcnt++;
      end else begin
        chk(wcnt == NWORDS, "R4 reads start after all writes", wcnt, NWORDS);
        chk(req_addr == addr_of(rqcnt), "R4 read address order", 64'(req_addr), 64'(addr_of(rqcnt)));
        q_dat[qt % 64] = mem[req_addr];
        if (rqcnt == bad_of(pass_no)) begin
          q_dat[qt % 64][0] = ~q_dat[qt % 64][0];
          bad_seen = 1;
          if (!exp_fail) begin exp_fail = 1; exp_faddr = req_addr; end
        end
        q_due[qt % 64] = cyc + lat_of(pass_no);
        qt++; rqcnt++;
      end
    end
    prev_done_full = 0;
    if (done) begin
      if (cur_full) begin
        chk(wcnt == NWORDS && rqcnt == NWORDS && retcnt == NWORDS, "R6 full pass before done",
            retcnt, NWORDS);
        chk(pass_ok == !bad_seen, "R5 R7 pass indication", 64'(pass_ok), 64'(!bad_seen));
        prev_done_full = seq_en;
      end else begin
        chk(wcnt == 0 && pass_ok, "R9 skipped pass reports done and ok", 64'(pass_ok), 1);
      end
      chk(fail_sticky == exp_fail, "R8 sticky fail flag", 64'(fail_sticky), 64'(exp_fail));
      if (exp_fail) chk(fail_addr == exp_faddr, "R8 first failing address", 64'(fail_addr), 64'(exp_faddr));
      wcnt = 0; rqcnt = 0; retcnt = 0; bad_seen = 0;
      gen = 32'h5EED0001;
      cur_full = seq_en;
      pass_no++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_valid && !done && !pass_ok && !fail_sticky && fail_addr == '0,
        "R10 outputs in reset", 64'(req_valid), 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    #1 chk(!req_valid && !done && !fail_sticky, "R10 idle cycle after reset", 64'(req_valid), 0);
    wait (pass_no == 5 && wcnt > 5);
    @(posedge clk); #1 seq_en = 0;   // mid-pass change, must not disturb pass 5
    wait (pass_no == 10);
    @(posedge clk); #1 seq_en = 1;
    wait (pass_no == 13);
    chk(!fail_sticky == 0, "R8 flag still set at end", 64'(fail_sticky), 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected=13 passes", pass_no);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule